// File: doc/BRIEF.md
# Warp Lane Permutation Mapper

This block decides which logical thread of a warp runs on each physical SIMD lane, and it splits the lanes into equal-width SIMD sets. When the block takes a strobe, it samples a warp identifier, the warp's active-thread mask and a mapping mode. One cycle later it presents, for every set:

- the thread index carried on each lane;
- which lanes of the set hold an active thread;
- the same activity expressed as a warp-order thread mask;
- the number of active threads;
- a flag that says whether the set has any work.

Two mappings are supported. The identity mapping puts thread T on lane T. The XOR mapping gives each warp its own fixed lane shuffle: lane P runs thread P XOR k, where k is the low lane-index bits of the warp identifier with their order reversed. Warps therefore spread their work over different lanes without any repacking. The mode field also encodes a full-compaction mapping and a reserved value. The block does not implement either of them and flags them as an error. A start-set input is accepted but has no influence on the placement.

Top module: `lane_perm_mapper`

## Requirements
- R1: In XOR mode (mode=1) the key k has LOG2(WARP_SIZE) bits. Bit i of the warp identifier becomes key bit LOG2(WARP_SIZE)-1-i. Identifier bits at or above LOG2(WARP_SIZE) have no effect.
- R2: Lane P carries thread P XOR k. Field P of `lane_thread` is bits [P*LOG2(WARP_SIZE) +: LOG2(WARP_SIZE)]. In identity mode (mode=0) k is zero, so lane P carries thread P.
- R3: Lane P belongs to set P / SET_W at position P % SET_W, where SET_W = WARP_SIZE / NUM_SETS. Its activity bit is `set_lane_mask[P]`, so set s owns bits [s*SET_W +: SET_W].
- R4: Lane P is active only when bit T of `act_mask` is 1, where T is the thread on that lane. In that case bit [s*WARP_SIZE + T] of `set_warp_mask` is also 1 for the lane's set s, and every other bit of that set's warp mask is 0.
- R5: `set_count` field s (CNT_W bits at s*CNT_W) holds the number of active lanes in set s. `set_valid[s]` is 1 exactly when that count is nonzero.
- R6: `start_set` has no effect on any output.
- R7: Mode 2 and mode 3 drive `mode_err`=1, all masks, counts and valid flags to zero, and `lane_thread` to the identity placement. Modes 0 and 1 drive `mode_err`=0.
- R8: `out_valid` pulses in the cycle after each cycle with `in_valid`=1. A strobe held for consecutive cycles yields one result per cycle. Without a strobe, all result outputs hold their values.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Strobe that samples the inputs |
| warp_id | input | WID_W | Warp identifier |
| act_mask | input | WARP_SIZE | Active-thread mask in warp order |
| mode | input | 2 | 0 identity, 1 XOR, 2 full compaction, 3 reserved |
| start_set | input | SS_W | Starting set; ignored |
| out_valid | output | 1 | Result strobe |
| lane_thread | output | WARP_SIZE*LOG2(WARP_SIZE) | Thread index per physical lane |
| set_lane_mask | output | WARP_SIZE | Per-set in-set lane activity |
| set_warp_mask | output | NUM_SETS*WARP_SIZE | Per-set warp-order activity |
| set_count | output | NUM_SETS*CNT_W | Active threads per set |
| set_valid | output | NUM_SETS | Set holds at least one active thread |
| mode_err | output | 1 | Unsupported mode was sampled |

## Verification
The bench builds the block with 16 lanes in 4 sets of 4 and a 6-bit warp identifier. With these values a sweep over all 16 XOR keys is short, and every lane and set is checked exhaustively. The two spare identifier bits are enough to show that high bits of the identifier have no effect. Because each set has 4 lanes, the full-count boundary (4) and the empty-set boundary (0) are both reached with simple mask patterns.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MAP_IDENT = 2'd0,
    MAP_XOR   = 2'd1,
    MAP_FULL  = 2'd2,
    MAP_RSVD  = 2'd3
  } map_mode_e;

  // Only identity and XOR placement are built into this block.
  function automatic logic mode_supported(input map_mode_e m);
    return (m == MAP_IDENT) || (m == MAP_XOR);
  endfunction

  // Thread placed on a physical lane under a given key.
  function automatic int unsigned thread_of_lane(input int unsigned lane,
                                                 input int unsigned key);
    return lane ^ key;
  endfunction

  // Reverse the order of the low n bits of v.
  function automatic int unsigned reverse_low(input int unsigned v,
                                              input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < n && v[i]) r |= (32'd1 << (n - 1 - i));
    end
    return r;
  endfunction

endpackage

// File: rtl/lpm_key_gen.sv
module lpm_key_gen
  import lpm_pkg::*;
#(
  parameter int LBITS = 5
) (
  input  logic [LBITS-1:0] id_low,
  input  map_mode_e        mode,
  output logic [LBITS-1:0] key,
  output logic             mode_bad
);

  logic [LBITS-1:0] rev;

  genvar i;
  generate
    for (i = 0; i < LBITS; i++) begin : g_rev
      assign rev[LBITS-1-i] = id_low[i];
    end
  endgenerate

  assign key      = (mode == MAP_XOR) ? rev : '0;
  assign mode_bad = !mode_supported(mode);

  always_comb begin
    if (mode == MAP_XOR) begin
      p_key_reversed_r1: assert (32'(key) == reverse_low(32'(id_low), LBITS));
    end else begin
      p_key_zero_r2: assert (key == '0);
    end
  end

endmodule

// File: rtl/lpm_set_slice.sv
module lpm_set_slice
  import lpm_pkg::*;
#(
  parameter int WARP_SIZE = 32,
  parameter int SET_W     = 8,
  parameter int LBITS     = 5,
  parameter int CNT_W     = 4,
  parameter int SET_IDX   = 0
) (
  input  logic [LBITS-1:0]       key,
  input  logic [WARP_SIZE-1:0]   act_mask,
  input  logic                   kill,
  output logic [SET_W*LBITS-1:0] thr_flat,
  output logic [SET_W-1:0]       lane_mask,
  output logic [WARP_SIZE-1:0]   warp_mask,
  output logic [CNT_W-1:0]       count
);

  logic [LBITS-1:0] thr [SET_W];

  genvar l;
  generate
    for (l = 0; l < SET_W; l++) begin : g_lane
      localparam int P = SET_IDX * SET_W + l;
      localparam logic [LBITS-1:0] PL = LBITS'(P);
      assign thr[l] = LBITS'(thread_of_lane(32'(PL), 32'(key)));
      assign thr_flat[l*LBITS +: LBITS] = thr[l];
      assign lane_mask[l] = act_mask[thr[l]] & ~kill;
    end
  endgenerate

  always_comb begin
    warp_mask = '0;
    for (int k = 0; k < SET_W; k++) begin
      if (lane_mask[k]) warp_mask[thr[k]] = 1'b1;
    end
  end

  always_comb begin
    count = '0;
    for (int k = 0; k < SET_W; k++) begin
      count = count + CNT_W'(lane_mask[k]);
    end
  end

  // Distinct lanes must land on distinct threads.
  always_comb begin
    p_slice_bijective_r4: assert ($countones(warp_mask) == $countones(lane_mask));
    p_slice_count_r5: assert (32'(count) == $countones(warp_mask));
  end

endmodule

// File: rtl/lane_perm_mapper.sv
module lane_perm_mapper
  import lpm_pkg::*;
#(
  parameter int WARP_SIZE = 32,
  parameter int NUM_SETS  = 4,
  parameter int WID_W     = 8,
  localparam int LBITS    = $clog2(WARP_SIZE),
  localparam int SET_W    = WARP_SIZE / NUM_SETS,
  localparam int CNT_W    = $clog2(SET_W + 1),
  localparam int SS_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [WID_W-1:0]          warp_id,
  input  logic [WARP_SIZE-1:0]      act_mask,
  input  logic [1:0]                mode,
  input  logic [SS_W-1:0]           start_set,
  output logic                      out_valid,
  output logic [WARP_SIZE*LBITS-1:0] lane_thread,
  output logic [WARP_SIZE-1:0]      set_lane_mask,
  output logic [NUM_SETS*WARP_SIZE-1:0] set_warp_mask,
  output logic [NUM_SETS*CNT_W-1:0] set_count,
  output logic [NUM_SETS-1:0]       set_valid,
  output logic                      mode_err
);

  map_mode_e                     mode_e;
  logic [LBITS-1:0]              key;
  logic                          mode_bad;
  logic [WARP_SIZE*LBITS-1:0]    thr_d;
  logic [WARP_SIZE-1:0]          lmask_d;
  logic [NUM_SETS*WARP_SIZE-1:0] wmask_d;
  logic [NUM_SETS*CNT_W-1:0]     cnt_d;
  logic [NUM_SETS-1:0]           vld_d;
  logic [WARP_SIZE-1:0]          warp_cover;

  assign mode_e = map_mode_e'(mode);

  lpm_key_gen #(.LBITS(LBITS)) u_key (
    .id_low   (warp_id[LBITS-1:0]),
    .mode     (mode_e),
    .key      (key),
    .mode_bad (mode_bad)
  );

  genvar s;
  generate
    for (s = 0; s < NUM_SETS; s++) begin : g_set
      lpm_set_slice #(
        .WARP_SIZE (WARP_SIZE),
        .SET_W     (SET_W),
        .LBITS     (LBITS),
        .CNT_W     (CNT_W),
        .SET_IDX   (s)
      ) u_slice (
        .key       (key),
        .act_mask  (act_mask),
        .kill      (mode_bad),
        .thr_flat  (thr_d[s*SET_W*LBITS +: SET_W*LBITS]),
        .lane_mask (lmask_d[s*SET_W +: SET_W]),
        .warp_mask (wmask_d[s*WARP_SIZE +: WARP_SIZE]),
        .count     (cnt_d[s*CNT_W +: CNT_W])
      );
      assign vld_d[s] = (cnt_d[s*CNT_W +: CNT_W] != '0);

      p_count_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(set_count[s*CNT_W +: CNT_W]) == $countones(set_lane_mask[s*SET_W +: SET_W]));
      p_valid_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid[s] == (set_warp_mask[s*WARP_SIZE +: WARP_SIZE] != '0));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      lane_thread   <= '0;
      set_lane_mask <= '0;
      set_warp_mask <= '0;
      set_count     <= '0;
      set_valid     <= '0;
      mode_err      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lane_thread   <= thr_d;
        set_lane_mask <= lmask_d;
        set_warp_mask <= wmask_d;
        set_count     <= cnt_d;
        set_valid     <= vld_d;
        mode_err      <= mode_bad;
      end
    end
  end

  // Union of the per-set warp masks: sets never claim the same thread.
  always_comb begin
    warp_cover = '0;
    for (int k = 0; k < NUM_SETS; k++) begin
      warp_cover |= set_warp_mask[k*WARP_SIZE +: WARP_SIZE];
    end
  end

  p_sets_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(warp_cover) == $countones(set_lane_mask));

  p_strobe_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(set_lane_mask) && $stable(lane_thread) &&
                   $stable(set_count) && $stable(mode_err)));

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (set_lane_mask == '0 && set_valid == '0 && set_warp_mask == '0));

  // Two strobes that differ only in start_set and the upper id bits give the same result.
  p_start_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(in_valid) && $stable(act_mask) && $stable(mode) &&
     $stable(warp_id[LBITS-1:0]) &&
     (!$stable(start_set) || !$stable(warp_id)))
    |=> ($stable(lane_thread) && $stable(set_lane_mask) && $stable(set_warp_mask)));

endmodule

// File: tb/lane_perm_mapper_bench.sv
module lane_perm_mapper_bench;

  localparam int W   = 16;
  localparam int NS  = 4;
  localparam int WID = 6;
  localparam int LB  = 4;
  localparam int SW  = W / NS;
  localparam int CW  = 3;
  localparam int SSW = 2;

  typedef struct packed {
    logic [W*LB-1:0] thr;
    logic [W-1:0]    lmask;
    logic [NS*W-1:0] wmask;
    logic [NS*CW-1:0] cnt;
    logic [NS-1:0]   vld;
    logic            err;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [WID-1:0] warp_id = '0;
  logic [W-1:0] act_mask = '0;
  logic [1:0] mode = '0;
  logic [SSW-1:0] start_set = '0;
  logic out_valid;
  logic [W*LB-1:0] lane_thread;
  logic [W-1:0] set_lane_mask;
  logic [NS*W-1:0] set_warp_mask;
  logic [NS*CW-1:0] set_count;
  logic [NS-1:0] set_valid;
  logic mode_err;

  int checks = 0;
  int failures = 0;
  exp_t q[$];
  string tags[$];
  exp_t last_exp;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_perm_mapper #(.WARP_SIZE(W), .NUM_SETS(NS), .WID_W(WID)) u_lane_perm_mapper (
    .clk, .rst_n, .in_valid, .warp_id, .act_mask, .mode, .start_set,
    .out_valid, .lane_thread, .set_lane_mask, .set_warp_mask,
    .set_count, .set_valid, .mode_err
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [WID-1:0] wid, input logic [W-1:0] am,
                                 input logic [1:0] md);
    exp_t e;
    int key;
    int cnt [NS];
    e = '0;
    key = 0;
    for (int b = 0; b < NS; b++) cnt[b] = 0;
    if (md == 2'd1) begin
      for (int i = 0; i < LB; i++) if (wid[i]) key += (1 << (LB - 1 - i));
    end
    for (int p = 0; p < W; p++) begin
      int t;
      int s;
      t = p ^ key;
      s = p / SW;
      e.thr[p*LB +: LB] = LB'(t);
      if (md < 2'd2 && am[t]) begin
        e.lmask[p] = 1'b1;
        e.wmask[s*W + t] = 1'b1;
        cnt[s]++;
      end
    end
    for (int s = 0; s < NS; s++) begin
      e.cnt[s*CW +: CW] = CW'(cnt[s]);
      e.vld[s] = (cnt[s] != 0);
    end
    e.err = (md >= 2'd2);
    return e;
  endfunction

  // Driver: one strobe per call, expected result pushed to the scoreboard.
  task automatic send(input logic [WID-1:0] wid, input logic [W-1:0] am,
                      input logic [1:0] md, input logic [SSW-1:0] ss,
                      input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    warp_id   = wid;
    act_mask  = am;
    mode      = md;
    start_set = ss;
    q.push_back(model(wid, am, md));
    tags.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares each result with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected out_valid", 64'(out_valid), 64'd0);
      end else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = tags.pop_front();
        last_exp = e;
        chk(lane_thread == e.thr, {t, " R2 lane_thread"}, 64'(lane_thread), 64'(e.thr));
        chk(set_lane_mask == e.lmask, {t, " R3 set_lane_mask"}, 64'(set_lane_mask), 64'(e.lmask));
        chk(set_warp_mask == e.wmask, {t, " R4 set_warp_mask"}, 64'(set_warp_mask), 64'(e.wmask));
        chk(set_count == e.cnt, {t, " R5 set_count"}, 64'(set_count), 64'(e.cnt));
        chk(set_valid == e.vld, {t, " R5 set_valid"}, 64'(set_valid), 64'(e.vld));
        chk(mode_err == e.err, {t, " R7 mode_err"}, 64'(mode_err), 64'(e.err));
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0 && mode_err == 1'b0, "R9 reset flags",
        64'({out_valid, mode_err}), 64'd0);
    chk(lane_thread == '0 && set_lane_mask == '0, "R9 reset lanes",
        64'(lane_thread), 64'd0);
    chk(set_warp_mask == '0 && set_count == '0 && set_valid == '0, "R9 reset sets",
        64'(set_warp_mask), 64'd0);
    rst_n = 1'b1;
    idle(2);

    send(6'd5, 16'hFFFF, 2'd0, 2'd0, "R2 identity all");
    send(6'd1, 16'h0001, 2'd1, 2'd0, "R1 R3 key8 single");
    send(6'd6, 16'hF0F0, 2'd1, 2'd0, "R1 key6");
    send(6'h35, 16'h1234, 2'd1, 2'd0, "R1 high id bits");
    send(6'd9, 16'h0000, 2'd1, 2'd0, "R5 empty");
    send(6'd3, 16'h00FF, 2'd0, 2'd1, "R4 identity half");
    idle(2);

    // R6: start_set varies, outputs must match the same model
    for (int ss = 0; ss < 4; ss++) send(6'd11, 16'hA5C3, 2'd1, 2'(ss), "R6 start_set");
    idle(2);

    // R7: unsupported modes
    send(6'd7, 16'hFFFF, 2'd2, 2'd0, "R7 mode2");
    send(6'd7, 16'hFFFF, 2'd3, 2'd1, "R7 mode3");
    send(6'd7, 16'hFFFF, 2'd1, 2'd0, "R7 recover");
    idle(2);

    // Full key sweep, back-to-back strobes
    for (int k = 0; k < 16; k++) send(6'(k), 16'h8421 ^ 16'(k * 16'h1111), 2'd1, 2'd0, "R1 sweep");
    send(6'd2, 16'h000F, 2'd1, 2'd0, "R5 full set");
    idle(1);

    // R8: hold while idle
    idle(4);
    chk(out_valid == 1'b0, "R8 idle out_valid", 64'(out_valid), 64'd0);
    chk(lane_thread == last_exp.thr && set_lane_mask == last_exp.lmask &&
        set_count == last_exp.cnt, "R8 hold", 64'(set_lane_mask), 64'(last_exp.lmask));
    chk(q.size() == 0, "R8 all results seen", 64'(q.size()), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule